// File: doc/BRIEF.md
# Watchdog Reset Controller with Keyed Register Writes

This peripheral holds three 32-bit registers on a plain register bus: a reset-control word, a boot-status word and a watchdog count. Software loads a 12-bit count and picks a reset configuration. The count then runs down once every sixteen clocks. When it expires with full reset selected, the block raises a system-reset pulse of fixed length. Every write must carry a key byte in its top eight bits. A write without that key is dropped without any effect.

The boot-status word sits in the power-on reset domain. The system reset that the watchdog produces does not clear it, so the next boot stage can still read it. Six of its bits, at the even positions 0 through 10, form a partition number. The block decodes that number onto its own outputs. The all-ones partition asks the boot flow to halt and stay in low power.

Top module: `wdr_ctrl`

## Requirements
- R1: After power-on reset, all three registers read 0, `wdt_rst` is low and `boot_part` is 0.
- R2: A write takes effect only when `wdata[31:24]` equals 8'h5A. A write with any other top byte leaves the addressed register unchanged.
- R3: Reads return the stored payload in bits 23:0, with bits 31:24 always 0. The control word stores all 24 payload bits exactly as written.
- R4: The control word is at offset 0x1C, the boot-status word at 0x20 and the watchdog count at 0x24. Any other offset reads 0.
- R5: A keyed write to 0x24 loads `wdata[11:0]` as the count, starts the countdown and restarts the prescaler. Reads of 0x24 return the live count in bits 11:0.
- R6: While running, the count drops by one every 16 clock cycles. The first decrement happens 16 edges after the loading write.
- R7: Full reset is selected when control bits 5:4 equal 2'b10. With full reset selected, a count of N makes `wdt_rst` first read high 16*(N+1) rising edges after the loading write edge. A count of 0 makes it read high after 16 edges.
- R8: The reset pulse lasts exactly 8 cycles. When it ends, control bits 5:4 are cleared while every other control bit stays as it was. The counter stays stopped at 0 and produces no further pulse.
- R9: If control bits 5:4 are not 2'b10 when the count expires, no pulse is produced and the counter stops at 0.
- R10: `sys_rst_n` low clears the control word and the count. The boot-status word is cleared only by `por_n`.
- R11: `boot_part[i]` equals boot-status bit 2*i for i = 0..5. `boot_halt` is high exactly when `boot_part` is 63, which is the pattern 0x555.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and register clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| sys_rst_n | input | 1 | System reset, active low, spares the boot-status word |
| addr | input | 8 | Register byte offset |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data, key byte in 31:24 |
| rdata | output | 32 | Read data for `addr` |
| wdt_rst | output | 1 | Full-system reset pulse, active high |
| boot_part | output | 6 | Partition number taken from the boot-status word |
| boot_halt | output | 1 | Partition number is the halt code |

## Verification
The hardest situation to reach is a system reset that arrives after the boot-status word has been set but before power-on reset. The control word and the count must be cleared in that situation while the boot-status word is kept. The bench stores the halt pattern, lets a full-reset expiry run to the end of its pulse, and then pulses `sys_rst_n`. It reads the boot-status word back both before and after a later `por_n` pulse. The exact expiry edge is hit by counting edges from the keyed load, for a nonzero count and for a count of zero.

// File: rtl/wdr_pkg.sv
package wdr_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned PAY_W    = 24;
  localparam logic [7:0]  KEY_BYTE = 8'h5A;
  localparam int unsigned OFF_CTRL = 'h1C;
  localparam int unsigned OFF_STAT = 'h20;
  localparam int unsigned OFF_CNT  = 'h24;
  localparam int unsigned CFG_LO   = 4;
  localparam int unsigned CFG_HI   = 5;
  localparam logic [1:0]  CFG_FULL = 2'b10;
endpackage

// File: rtl/wdr_prescaler.sv
module wdr_prescaler #(
  parameter int unsigned DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] pre_q, pre_d;

  always_comb begin
    pre_d = pre_q;
    if (clr)
      pre_d = '0;
    else if (en)
      pre_d = (pre_q == LAST) ? '0 : pre_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick = en && !clr && (pre_q == LAST);
endmodule

// File: rtl/wdr_countdown.sv
module wdr_countdown #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (load) begin
      cnt_d = load_val;
      run_d = 1'b1;
    end else if (run_q && tick) begin
      if (cnt_q == '0) run_d = 1'b0;
      else             cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign cnt     = cnt_q;
  assign running = run_q;
  assign expire  = run_q && tick && !load && (cnt_q == '0);
endmodule

// File: rtl/wdr_pulse.sv
module wdr_pulse #(
  parameter int unsigned LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active,
  output logic done
);
  localparam int unsigned W = (LEN > 1) ? $clog2(LEN) : 1;

  logic         act_q, act_d;
  logic [W-1:0] left_q, left_d;

  always_comb begin
    act_d  = act_q;
    left_d = left_q;
    if (act_q) begin
      if (left_q == '0) act_d = 1'b0;
      else              left_d = left_q - W'(1);
    end else if (fire) begin
      act_d  = 1'b1;
      left_d = W'(LEN - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      left_q <= '0;
    end else begin
      act_q  <= act_d;
      left_q <= left_d;
    end
  end

  assign active = act_q;
  assign done   = act_q && (left_q == '0);
endmodule

// File: rtl/wdr_ctrl.sv
module wdr_ctrl
  import wdr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned PRESCALE  = 16,
  parameter int unsigned PULSE_LEN = 8,
  parameter int unsigned PART_W    = 6
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              wdt_rst,
  output logic [PART_W-1:0] boot_part,
  output logic              boot_halt
);
  logic sys_rst_c;
  assign sys_rst_c = por_n & sys_rst_n;

  logic wr_ok, sel_ctrl, sel_stat, sel_cnt;
  assign wr_ok    = wr_en && (wdata[DATA_W-1:PAY_W] == KEY_BYTE);
  assign sel_ctrl = (addr == ADDR_W'(OFF_CTRL));
  assign sel_stat = (addr == ADDR_W'(OFF_STAT));
  assign sel_cnt  = (addr == ADDR_W'(OFF_CNT));

  logic [PAY_W-1:0] rstc_q, rstc_d;
  logic [PAY_W-1:0] rsts_q, rsts_d;
  logic             load, tick, running, expire, fire, p_done;
  logic [CNT_W-1:0] cnt;

  assign load = wr_ok && sel_cnt;
  assign fire = expire && (rstc_q[CFG_HI:CFG_LO] == CFG_FULL);

  wdr_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst_n(sys_rst_c), .clr(load), .en(running), .tick(tick)
  );

  wdr_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(sys_rst_c), .load(load), .load_val(wdata[CNT_W-1:0]),
    .tick(tick), .cnt(cnt), .running(running), .expire(expire)
  );

  wdr_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(sys_rst_c), .fire(fire), .active(wdt_rst), .done(p_done)
  );

  always_comb begin
    rstc_d = rstc_q;
    if (p_done)
      rstc_d[CFG_HI:CFG_LO] = '0;
    if (wr_ok && sel_ctrl)
      rstc_d = wdata[PAY_W-1:0];
  end

  always_ff @(posedge clk or negedge sys_rst_c) begin
    if (!sys_rst_c) rstc_q <= '0;
    else            rstc_q <= rstc_d;
  end

  always_comb begin
    rsts_d = rsts_q;
    if (wr_ok && sel_stat)
      rsts_d = wdata[PAY_W-1:0];
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) rsts_q <= '0;
    else        rsts_q <= rsts_d;
  end

  always_comb begin
    rdata = '0;
    if (sel_ctrl)     rdata[PAY_W-1:0] = rstc_q;
    else if (sel_stat) rdata[PAY_W-1:0] = rsts_q;
    else if (sel_cnt)  rdata[CNT_W-1:0] = cnt;
  end

  for (genvar i = 0; i < PART_W; i++) begin : g_part
    assign boot_part[i] = rsts_q[2*i];
  end
  assign boot_halt = &boot_part;
endmodule

// File: rtl/wdr_ctrl_chk.sv
module wdr_ctrl_chk #(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned PULSE_LEN = 8
) (
  input logic             clk,
  input logic             por_n,
  input logic             sys_rst_n,
  input logic             wr_en,
  input logic [31:0]      wdata,
  input logic [31:0]      rdata,
  input logic             wdt_rst,
  input logic [23:0]      rsts_q,
  input logic [1:0]       cfg,
  input logic [CNT_W-1:0] cnt,
  input logic             load
);
  logic [7:0] hi_cnt;
  logic       rst_all;
  assign rst_all = por_n & sys_rst_n;

  always_ff @(posedge clk or negedge rst_all) begin
    if (!rst_all)     hi_cnt <= '0;
    else if (wdt_rst) hi_cnt <= hi_cnt + 8'd1;
    else              hi_cnt <= '0;
  end

  AST_RD_KEY_ZERO: assert property (@(posedge clk) disable iff (!rst_all)
    rdata[31:24] == 8'h00); // R3

  AST_UNKEYED_STAT_HELD: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && wdata[31:24] != 8'h5A) |=> $stable(rsts_q)); // R2

  AST_STAT_SURVIVES: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst_n && !wr_en) |=> $stable(rsts_q)); // R10

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_all)
    !load |=> (cnt == $past(cnt) || cnt == $past(cnt) - CNT_W'(1))); // R6

  AST_PULSE_CFG: assert property (@(posedge clk) disable iff (!rst_all)
    $rose(wdt_rst) |-> $past(cfg) == 2'b10); // R7

  AST_PULSE_MAX: assert property (@(posedge clk) disable iff (!rst_all)
    hi_cnt <= 8'(PULSE_LEN)); // R8

  AST_PULSE_FULL: assert property (@(posedge clk) disable iff (!rst_all)
    $fell(wdt_rst) |-> hi_cnt == 8'(PULSE_LEN)); // R8
endmodule

bind wdr_ctrl wdr_ctrl_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .wr_en(wr_en),
  .wdata(wdata), .rdata(rdata), .wdt_rst(wdt_rst), .rsts_q(rsts_q),
  .cfg(rstc_q[5:4]), .cnt(cnt), .load(load)
);

// File: tb/tb_wdr_ctrl.sv
module tb_wdr_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  logic        clk, por_n, sys_rst_n, wr_en;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic        wdt_rst, boot_halt;
  logic [5:0]  boot_part;

  int n_chk = 0;
  int n_fail = 0;

  wdr_ctrl dut (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .addr(addr),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .wdt_rst(wdt_rst),
    .boot_part(boot_part), .boot_halt(boot_halt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // {write, offset, data, expected readback, requirement number}
  localparam logic [80:0] VECS [0:NVEC-1] = '{
    {1'b0, 8'h1C, 32'h0000_0000, 32'h0000_0000, 8'd1},  // R1
    {1'b0, 8'h20, 32'h0000_0000, 32'h0000_0000, 8'd1},  // R1
    {1'b0, 8'h24, 32'h0000_0000, 32'h0000_0000, 8'd1},  // R1
    {1'b1, 8'h1C, 32'h5A00_1234, 32'h0000_1234, 8'd4},  // R4
    {1'b1, 8'h1C, 32'h3300_FFFF, 32'h0000_1234, 8'd2},  // R2
    {1'b1, 8'h20, 32'h5A00_0555, 32'h0000_0555, 8'd4},  // R4
    {1'b1, 8'h20, 32'hA500_0000, 32'h0000_0555, 8'd2},  // R2
    {1'b1, 8'h1C, 32'h5AFF_FFFF, 32'h00FF_FFFF, 8'd3},  // R3
    {1'b0, 8'h28, 32'h0000_0000, 32'h0000_0000, 8'd4},  // R4
    {1'b1, 8'h24, 32'h5A00_F123, 32'h0000_0123, 8'd5}   // R5
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int k, first, width;
    bit seen;
    por_n = 1'b0; sys_rst_n = 1'b1; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    chk(wdt_rst == 1'b0, "R1", {31'b0, wdt_rst}, 32'h0);
    chk(boot_part == 6'd0, "R1", {26'b0, boot_part}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i][80]) wr(VECS[i][79:72], VECS[i][71:40]);
      rd(VECS[i][79:72], v);
      chk(v == VECS[i][39:8], $sformatf("R%0d vec%0d", VECS[i][7:0], i), v, VECS[i][39:8]);
    end

    // R6: decrement every 16 edges; R9: expiry without full reset
    wr(8'h1C, 32'h5A00_0000);
    wr(8'h24, 32'h5A00_0005);
    seen = 0;
    for (k = 1; k <= 120; k++) begin
      @(negedge clk);
      if (k == 15) begin rd(8'h24, v); chk(v == 32'd5, "R6", v, 32'd5); end
      if (k == 16) begin rd(8'h24, v); chk(v == 32'd4, "R6", v, 32'd4); end
      if (k == 32) begin rd(8'h24, v); chk(v == 32'd3, "R6", v, 32'd3); end
      if (wdt_rst) seen = 1;
    end
    chk(!seen, "R9", {31'b0, seen}, 32'h0);
    rd(8'h24, v); chk(v == 32'd0, "R9", v, 32'd0);

    // R7: full reset, count 3 -> rise after 64 edges
    wr(8'h1C, 32'h5A00_00A1 | 32'h00AB_C000);
    wr(8'h24, 32'h5A00_0003);
    first = -1;
    for (k = 1; k <= 80 && first < 0; k++) begin
      @(negedge clk);
      if (wdt_rst) first = k;
    end
    chk(first == 64, "R7", first, 64);
    // R8: width 8, then config cleared, others kept
    width = 1;
    for (k = 0; k < 20; k++) begin
      @(negedge clk);
      if (wdt_rst) width++;
    end
    chk(width == 8, "R8", width, 8);
    rd(8'h1C, v); chk(v == 32'h00AB_C081, "R8", v, 32'h00AB_C081);
    rd(8'h24, v); chk(v == 32'd0, "R8", v, 32'd0);
    seen = 0;
    for (k = 0; k < 100; k++) begin @(negedge clk); if (wdt_rst) seen = 1; end
    chk(!seen, "R8", {31'b0, seen}, 32'h0);

    // R11: halt decode of stored 0x555
    chk(boot_part == 6'd63 && boot_halt, "R11", {25'b0, boot_halt, boot_part}, 32'h7F);

    // R10: system reset keeps boot-status word
    wr(8'h24, 32'h5A00_0077);
    @(negedge clk); sys_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    sys_rst_n = 1'b1;
    rd(8'h20, v); chk(v == 32'h555, "R10", v, 32'h555);
    rd(8'h1C, v); chk(v == 32'h0, "R10", v, 32'h0);
    rd(8'h24, v); chk(v == 32'h0, "R10", v, 32'h0);
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    rd(8'h20, v); chk(v == 32'h0, "R10", v, 32'h0);

    // R11: partition 26 from bits 2,6,8
    wr(8'h20, 32'h5A00_0144);
    chk(boot_part == 6'd26 && !boot_halt, "R11", {25'b0, boot_halt, boot_part}, 32'h1A);

    // R7: count zero -> rise after 16 edges
    wr(8'h1C, 32'h5A00_0020);
    wr(8'h24, 32'h5A00_0000);
    first = -1;
    for (k = 1; k <= 40 && first < 0; k++) begin
      @(negedge clk);
      if (wdt_rst) first = k;
    end
    chk(first == 16, "R7", first, 16);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule